// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block gives software control of twelve general-purpose pins through a small bank of 32-bit word registers. Each pin can be driven from an output-data bit, released through an output-enable bit, and read back after a two-flop synchronizer. The same synchronized levels feed an interrupt path. Each pin compares its level against a polarity bit. A pin at its active level latches a sticky status bit. Software clears that bit by writing a one to it. The block raises one combined interrupt line whenever an unmasked status bit is set.

The interrupt is level-sensitive but latched. If software acknowledges a status bit while its pin is still at the active level, the bit does not drop, because a new set condition always overrides the clear. The polarity controls sit at a stride of four bits and are split over two words: one word serves pins 0-7 and the other serves pins 8-11. A further 32-bit word holds the pin-mux selection. It is presented on an output port for pad logic outside the block and has no other effect inside.

The bus side uses byte addresses and only the word index `addr[4:2]` is decoded. The word offsets are: 0x00 output data, 0x04 output enable, 0x08 input level, 0x0C status, 0x10 polarity for pins 0-7, 0x14 interrupt enable, 0x18 polarity for pins 8-11, and 0x1C mux word.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After a synchronous reset every register reads 0, `pin_oe`, `pin_out`, `mux_sel` and `irq` are 0, and so every pin starts as an input with interrupts masked and active-high polarity.
- R2: A write to 0x00 or 0x04 updates `pin_out` or `pin_oe` at the write's clock edge. Only bits 11:0 are stored, and bits 31:12 read as 0.
- R3: A read issued with `rd_en` at a clock edge returns its data on `rd_data` from that edge onward. Word 0x08 returns the pin levels after two synchronizer flops, zero-extended. Writes to 0x08 are ignored.
- R4: Pin n (n<8) takes its polarity from bit 4n of word 0x10. Pin n (n≥8) takes its polarity from bit 4(n-8) of word 0x18. A polarity bit of 0 means active-high and 1 means active-low.
- R5: A status bit at 0x0C (bit n for pin n) sets on the clock edge after the synchronized pin is at its active level, and stays set until it is acknowledged.
- R6: Writing 0x0C clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R7: A status bit acknowledged while its pin is still at its active level stays set, because a set condition overrides a clear in the same cycle.
- R8: `irq` is a register that goes high one cycle after any status bit whose enable bit at 0x14 is 1 is set. Masked status bits do not raise it.
- R9: Word 0x1C is a full 32-bit read/write word that appears on `mux_sel` and has no effect on the pins or interrupts.
- R10: Words 0x10 and 0x18 are full 32-bit read/write words, including the bits that select no polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output-data levels |
| pin_oe | output | 12 | Per-pin drive enable; 0 means tri-stated |
| mux_sel | output | 32 | Pin-mux selection word |
| irq | output | 1 | Combined interrupt |

## Verification
The results arrive at different delays. A register write shows on `pin_out`, `pin_oe` and `mux_sel` at the write's own edge. Read data shows one edge after `rd_en`. A pin change takes two edges to pass the synchronizer, one more to reach status, and one more to reach `irq`. The bench drives inputs on falling edges and compares on falling edges. A read pushes its expected word into a queue, and a monitor pops that word on the falling edge after the strobe is registered. After each pin change the bench waits four falling edges, which is more than the three-edge status path, before it reads status or samples `irq`.

// File: rtl/gpio_lvl_irq_pkg.sv
package gpio_lvl_irq_pkg;

  // Word index taken from addr[4:2]; the order fixes the software offsets.
  typedef enum logic [2:0] {
    WI_DOUT  = 3'd0,
    WI_DOE   = 3'd1,
    WI_DIN   = 3'd2,
    WI_STS   = 3'd3,
    WI_POLA  = 3'd4,
    WI_IEN   = 3'd5,
    WI_POLB  = 3'd6,
    WI_MUX   = 3'd7
  } word_idx_e;

  localparam int unsigned POL_STRIDE    = 4;
  localparam int unsigned PINS_PER_BANK = 8;

endpackage

// File: rtl/gpio_lvl_irq_sync.sv
module gpio_lvl_irq_sync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_lvl_irq_core.sv
module gpio_lvl_irq_core
  import gpio_lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl_sync,
  input  logic [DATA_W-1:0]   pol_lo,
  input  logic [DATA_W-1:0]   pol_hi,
  input  logic [NUM_PINS-1:0] ien,
  input  logic [NUM_PINS-1:0] ack_mask,
  output logic [NUM_PINS-1:0] status,
  output logic                irq_q
);

  logic [NUM_PINS-1:0] pol_bit;
  logic [NUM_PINS-1:0] active;
  logic [NUM_PINS-1:0] sts_q;
  logic                unused_pol;

  // Pick each pin's polarity bit from its bank at a fixed stride.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pol
    if (p < PINS_PER_BANK) begin : g_lo
      assign pol_bit[p] = pol_lo[POL_STRIDE*p];
    end else begin : g_hi
      assign pol_bit[p] = pol_hi[POL_STRIDE*(p-PINS_PER_BANK)];
    end
  end

  assign unused_pol = ^{pol_lo, pol_hi};
  assign active     = lvl_sync ^ pol_bit;

  // The set condition wins over an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= active | (sts_q & ~ack_mask);
      irq_q <= |(sts_q & ien);
    end
  end

  assign status = sts_q;

  AST_ACTIVE_SETS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(active) & ~sts_q) == '0));  // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(sts_q) & ~$past(ack_mask) & ~sts_q) == '0));  // R6

  AST_ACK_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ((ack_mask & active) != '0) |=> ((($past(ack_mask) & $past(active)) & ~sts_q) == '0));  // R7

endmodule

// File: rtl/gpio_lvl_irq_regs.sv
module gpio_lvl_irq_regs
  import gpio_lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] lvl_sync,
  input  logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] dout_q,
  output logic [NUM_PINS-1:0] doe_q,
  output logic [NUM_PINS-1:0] ien_q,
  output logic [DATA_W-1:0]   pol_lo_q,
  output logic [DATA_W-1:0]   pol_hi_q,
  output logic [DATA_W-1:0]   mux_q,
  output logic [NUM_PINS-1:0] ack_mask
);

  localparam int unsigned IDX_W = 3;

  word_idx_e          idx;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rd_q;
  logic               unused_addr;

  assign idx         = word_idx_e'(addr[IDX_W+1:2]);
  assign unused_addr = ^addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      doe_q    <= '0;
      ien_q    <= '0;
      pol_lo_q <= '0;
      pol_hi_q <= '0;
      mux_q    <= '0;
    end else if (wr_en) begin
      case (idx)
        WI_DOUT: dout_q   <= wr_data[NUM_PINS-1:0];
        WI_DOE:  doe_q    <= wr_data[NUM_PINS-1:0];
        WI_IEN:  ien_q    <= wr_data[NUM_PINS-1:0];
        WI_POLA: pol_lo_q <= wr_data;
        WI_POLB: pol_hi_q <= wr_data;
        WI_MUX:  mux_q    <= wr_data;
        default: ;
      endcase
    end
  end

  assign ack_mask = (wr_en && idx == WI_STS) ? wr_data[NUM_PINS-1:0] : '0;

  always_comb begin
    case (idx)
      WI_DOUT: rd_mux = DATA_W'(dout_q);
      WI_DOE:  rd_mux = DATA_W'(doe_q);
      WI_DIN:  rd_mux = DATA_W'(lvl_sync);
      WI_STS:  rd_mux = DATA_W'(status);
      WI_POLA: rd_mux = pol_lo_q;
      WI_IEN:  rd_mux = DATA_W'(ien_q);
      WI_POLB: rd_mux = pol_hi_q;
      default: rd_mux = mux_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  AST_STS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == WI_STS) |=> (rd_data[DATA_W-1:NUM_PINS] == '0));  // R6

  AST_DIN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == WI_DIN) |=> ($stable(dout_q) && $stable(doe_q) && $stable(ien_q)));  // R3

endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [DATA_W-1:0]   mux_sel,
  output logic                irq
);

  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] status;
  logic [NUM_PINS-1:0] ien;
  logic [NUM_PINS-1:0] ack_mask;
  logic [DATA_W-1:0]   pol_lo;
  logic [DATA_W-1:0]   pol_hi;

  gpio_lvl_irq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .q_sync  (lvl_sync)
  );

  gpio_lvl_irq_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .lvl_sync (lvl_sync),
    .status   (status),
    .dout_q   (pin_out),
    .doe_q    (pin_oe),
    .ien_q    (ien),
    .pol_lo_q (pol_lo),
    .pol_hi_q (pol_hi),
    .mux_q    (mux_sel),
    .ack_mask (ack_mask)
  );

  gpio_lvl_irq_core #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .lvl_sync (lvl_sync),
    .pol_lo   (pol_lo),
    .pol_hi   (pol_hi),
    .ien      (ien),
    .ack_mask (ack_mask),
    .status   (status),
    .irq_q    (irq)
  );

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && irq == 1'b0));  // R1

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(status & ien) != '0));  // R8

endmodule

// File: tb/gpio_lvl_irq_tb.sv
module gpio_lvl_irq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out;
  logic [11:0] pin_oe;
  logic [31:0] mux_sel;
  logic        irq;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;
  logic        rd_pend = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lvl_irq u_dut (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .mux_sel (mux_sel),
    .irq     (irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: a read strobed at an edge is compared on the next falling edge.
  always @(posedge clk) rd_pend <= rd_en && !rst;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        check(rd_data, 32'hxxxxxxxx, "scoreboard underflow");
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({20'd0, pin_oe}, 32'h0, "R1 pin_oe");
    check({20'd0, pin_out}, 32'h0, "R1 pin_out");
    check({31'd0, irq}, 32'h0, "R1 irq");
    check(mux_sel, 32'h0, "R1 mux_sel");
    for (int w = 0; w < 8; w++) rd(5'(w * 4), 32'h0, "R1 register reset");

    // R2 output data and enable
    wr(5'h00, 32'hFFFF_FFFF);
    check({20'd0, pin_out}, 32'h0000_0FFF, "R2 pin_out");
    rd(5'h00, 32'h0000_0FFF, "R2 dout upper bits zero");
    wr(5'h04, 32'h8000_05A5);
    check({20'd0, pin_oe}, 32'h0000_05A5, "R2 pin_oe");
    rd(5'h04, 32'h0000_05A5, "R2 doe readback");

    // R3 input sampling and ignored writes
    pin_in = 12'hA53;
    idle(4);
    rd(5'h08, 32'h0000_0A53, "R3 input level");
    wr(5'h08, 32'hFFFF_F000);
    rd(5'h08, 32'h0000_0A53, "R3 input write ignored");
    check({20'd0, pin_out}, 32'h0000_0FFF, "R3 write to input leaves pin_out");

    // R5 status latched, R7 ack while active keeps it
    rd(5'h0C, 32'h0000_0A53, "R5 status latched");
    wr(5'h0C, 32'h0000_0FFF);
    rd(5'h0C, 32'h0000_0A53, "R7 ack while active");
    pin_in = 12'h000;
    idle(4);
    rd(5'h0C, 32'h0000_0A53, "R5 status sticky after release");
    wr(5'h0C, 32'h0000_0003);
    rd(5'h0C, 32'h0000_0A50, "R6 partial clear");
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, 32'h0, "R6 full clear");

    // R8 combined interrupt
    wr(5'h14, 32'h0000_0010);
    rd(5'h14, 32'h0000_0010, "R8 enable readback");
    pin_in = 12'h010;
    idle(5);
    check({31'd0, irq}, 32'h1, "R8 irq on enabled status");
    wr(5'h14, 32'h0000_0001);
    idle(2);
    check({31'd0, irq}, 32'h0, "R8 masked status");
    pin_in = 12'h000;
    idle(4);
    wr(5'h0C, 32'h0000_0FFF);
    idle(2);
    rd(5'h0C, 32'h0, "R6 cleared after release");

    // R10 polarity words are full read/write
    wr(5'h18, 32'h1234_5678);
    rd(5'h18, 32'h1234_5678, "R10 polarity hi readback");
    wr(5'h10, 32'hEEEE_EEEE);
    rd(5'h10, 32'hEEEE_EEEE, "R10 polarity lo readback");
    wr(5'h10, 32'h0);
    wr(5'h18, 32'h0);
    idle(4);
    wr(5'h0C, 32'h0000_0FFF);
    idle(2);
    rd(5'h0C, 32'h0, "R10 status clear after restore");

    // R4 polarity mapping: pin1 -> lo bit4, pin10 -> hi bit8
    wr(5'h10, 32'h0000_0010);
    wr(5'h18, 32'h0000_0100);
    idle(4);
    rd(5'h0C, 32'h0000_0402, "R4 active-low pins at low level");
    wr(5'h14, 32'h0000_0400);
    idle(2);
    check({31'd0, irq}, 32'h1, "R4 active-low pin raises irq");
    pin_in = 12'h402;
    idle(4);
    wr(5'h0C, 32'h0000_0FFF);
    idle(2);
    rd(5'h0C, 32'h0, "R4 active-low pins at high level inactive");
    idle(2);
    check({31'd0, irq}, 32'h0, "R4 irq drops after clear");

    // R9 mux word
    wr(5'h1C, 32'hDEAD_BEEF);
    check(mux_sel, 32'hDEAD_BEEF, "R9 mux_sel port");
    rd(5'h1C, 32'hDEAD_BEEF, "R9 mux readback");
    check({20'd0, pin_out}, 32'h0000_0FFF, "R9 pin_out unchanged");
    check({20'd0, pin_oe}, 32'h0000_05A5, "R9 pin_oe unchanged");
    rd(5'h0C, 32'h0, "R9 status unchanged");

    idle(3);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "scoreboard drained");
    finish_run();
  end

endmodule